// File: doc/BRIEF.md
# Instruction-Armed Watchdog Timer

This block is a watchdog timer driven from the instruction decoder of a small CPU. It watches the stream of executed opcodes. The first time the watchdog opcode (0x5F) runs, the timer is armed. Every later 0x5F restarts the timeout window. After arming, nothing except a system reset can disarm it. If a whole window passes without a refresh, the block sends a one-cycle reset request to the reset controller.

Each execution of 0x5F also forces three condition flags, one cycle later: zero is set, sign is cleared and overflow is cleared. The block drives write strobes and values for these three flags toward the flag register. Other flags are never written. A run-enable input reports whether the oscillator is running. While it is low (deep sleep, with the oscillator stopped), the count freezes. While it is high, including light sleep where only the CPU clock is gated, the count advances.

Top module: `wdtTop`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rstReq` and `flagWr` are 0. The count is 0 and the watchdog is disarmed.
- R2: While disarmed, `rstReq` is never asserted, however many cycles pass.
- R3: An opcode 0x5F with `opValid` high arms the watchdog and starts a window of TIMEOUT counted edges. If no later 0x5F arrives, `rstReq` is high in the cycle after the TIMEOUT-th counted edge that follows the opcode.
- R4: Each 0x5F executed while armed restarts the window from zero.
- R5: `rstReq` is high for exactly one cycle. The watchdog stays armed afterwards, and it requests again after another full window if no refresh arrives.
- R6: An opcode other than 0x5F, or any opcode presented with `opValid` low, neither arms nor refreshes the watchdog.
- R7: In the cycle after each 0x5F, `flagWr` is 3'b111 (bit 2 zero, bit 1 sign, bit 0 overflow), `flagZ`=1, `flagS`=0 and `flagV`=0. In every other cycle `flagWr` is 3'b000.
- R8: Edges with `runEn` low do not advance the count and cannot raise `rstReq`.
- R9: A 0x5F that arrives on the edge where the count would expire wins: no request is issued and the window restarts.
- R10: A system reset disarms the watchdog. After reset, no request is issued until 0x5F runs again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous system reset |
| opValid | input | 1 | An opcode is executed this cycle |
| opCode | input | 8 | Executed opcode byte |
| runEn | input | 1 | Oscillator running; low freezes the count |
| rstReq | output | 1 | One-cycle device reset request |
| flagWr | output | 3 | Flag write strobes {zero, sign, overflow} |
| flagZ | output | 1 | Zero flag value |
| flagS | output | 1 | Sign flag value |
| flagV | output | 1 | Overflow flag value |

## Verification
The block is exercised with several opcode streams, and each one separates a different faulty timer.

- A long idle stream before arming separates a timer that starts on its own from one that waits for 0x5F.
- A single 0x5F followed by silence places the request on one exact cycle, which exposes an off-by-one window. The second request that follows shows the armed state is sticky.
- Refreshes spaced just under a window, and one placed on the expiry edge itself, tell a restarting counter from a free-running one. They also show the priority of refresh over expiry.
- Neighbouring opcodes and opcodes presented with `opValid` low show that the decode is exact.
- A burst with `runEn` low shows that the count freezes rather than resets.
- A mid-run reset shows that the watchdog disarms.

// File: rtl/wdtPkg.sv
package wdtPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // restart the window
    logic step;   // advance the count
    logic fire;   // window expired: request reset
    logic flag;   // write condition flags
  } wdtStrobe_t;
endpackage

// File: rtl/wdtCtrl.sv
module wdtCtrl #(
  parameter int TIMEOUT = 16,
  parameter logic [7:0] WDT_OP = 8'h5F,
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [7:0]          opCode,
  input  logic                runEn,
  input  logic [CW-1:0]       cnt,
  output wdtPkg::wdtStrobe_t  strobe
);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic isWdt;
  logic armed;
  logic atEnd;
  logic counting;

  assign isWdt    = opValid && (opCode == WDT_OP);
  assign atEnd    = (cnt == LAST);
  assign counting = armed && runEn && !isWdt;

  // Sticky arm: only reset clears it
  always_ff @(posedge clk) begin
    if (!rstN)      armed <= 1'b0;
    else if (isWdt) armed <= 1'b1;
  end

  always_comb begin
    strobe.load = isWdt;
    strobe.flag = isWdt;
    strobe.step = counting && !atEnd;
    strobe.fire = counting && atEnd;
  end
endmodule

// File: rtl/wdtData.sv
module wdtData #(
  parameter int TIMEOUT = 16,
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  wdtPkg::wdtStrobe_t  strobe,
  output logic [CW-1:0]       cnt,
  output logic                rstReq,
  output logic [2:0]          flagWr,
  output logic                flagZ,
  output logic                flagS,
  output logic                flagV
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.load || strobe.fire) begin
      cnt <= '0;
    end else if (strobe.step) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstReq <= 1'b0;
      flagWr <= 3'b000;
      flagZ  <= 1'b0;
    end else begin
      rstReq <= strobe.fire;
      flagWr <= {3{strobe.flag}};
      flagZ  <= strobe.flag;
    end
  end

  // Sign and overflow are always written as zero
  assign flagS = 1'b0;
  assign flagV = 1'b0;
endmodule

// File: rtl/wdtTop.sv
module wdtTop #(
  parameter int TIMEOUT = 16,
  parameter logic [7:0] WDT_OP = 8'h5F,
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [7:0] opCode,
  input  logic       runEn,
  output logic       rstReq,
  output logic [2:0] flagWr,
  output logic       flagZ,
  output logic       flagS,
  output logic       flagV
);
  wdtPkg::wdtStrobe_t strobe;
  logic [CW-1:0] cnt;

  wdtCtrl #(.TIMEOUT(TIMEOUT), .WDT_OP(WDT_OP)) i_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .runEn(runEn), .cnt(cnt), .strobe(strobe)
  );

  wdtData #(.TIMEOUT(TIMEOUT)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cnt(cnt),
    .rstReq(rstReq), .flagWr(flagWr), .flagZ(flagZ),
    .flagS(flagS), .flagV(flagV)
  );
endmodule

// File: rtl/wdtChecker.sv
module wdtChecker #(
  parameter int TIMEOUT = 16,
  parameter logic [7:0] WDT_OP = 8'h5F,
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          opValid,
  input logic [7:0]    opCode,
  input logic          runEn,
  input logic [CW-1:0] cnt,
  input logic          rstReq,
  input logic [2:0]    flagWr,
  input logic          flagZ,
  input logic          flagS,
  input logic          flagV
);
  logic isWdt;
  assign isWdt = opValid && (opCode == WDT_OP);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  a_r9_refresh_wins: assert property (@(posedge clk) disable iff (!rstN)
    isWdt |=> !rstReq);

  a_r8_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !isWdt) |=> ($stable(cnt) && !rstReq));

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CW'(TIMEOUT - 1));

  a_r7_flags: assert property (@(posedge clk) disable iff (!rstN)
    isWdt |=> (flagWr == 3'b111 && flagZ && !flagS && !flagV));
endmodule

bind wdtTop wdtChecker #(.TIMEOUT(TIMEOUT), .WDT_OP(WDT_OP)) i_wdtChecker (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
  .runEn(runEn), .cnt(cnt), .rstReq(rstReq), .flagWr(flagWr),
  .flagZ(flagZ), .flagS(flagS), .flagV(flagV)
);

// File: tb/test_wdtTop.sv
module test_wdtTop;
  localparam int TIMEOUT = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [7:0] opCode = 8'h00;
  logic       runEn = 1'b1;
  logic       rstReq;
  logic [2:0] flagWr;
  logic       flagZ, flagS, flagV;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string tag = "R1";

  // Reference model state
  bit mArmed = 0;
  int mCnt = 0;
  bit mReq = 0;
  bit mFlag = 0;
  int reqSeen = 0;

  always #4 clk = ~clk;

  wdtTop #(.TIMEOUT(TIMEOUT)) i_wdtTop (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .runEn(runEn), .rstReq(rstReq), .flagWr(flagWr),
    .flagZ(flagZ), .flagS(flagS), .flagV(flagV)
  );

  // Behavioural model, advanced on every edge from the inputs
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mArmed = 0; mCnt = 0; mReq = 0; mFlag = 0;
    end else begin
      mReq = 0;
      mFlag = (opValid && opCode == 8'h5F);
      if (mFlag) begin
        mArmed = 1; mCnt = 0;
      end else if (mArmed && runEn) begin
        mCnt++;
        if (mCnt == TIMEOUT) begin
          mReq = 1; mCnt = 0;
        end
      end
    end
  end

  task automatic compare();
    logic [5:0] exp, act;
    exp = {mReq, {3{mFlag}}, mFlag, 1'b0};
    act = {rstReq, flagWr, flagZ, flagS};
    checks++;
    if (act[5] !== exp[5]) begin
      errors++;
      $display("FAIL %s rstReq actual=%0b expected=%0b at cycle %0d", tag, act[5], exp[5], cycles);
    end
    checks++;
    if (act[4:0] !== exp[4:0] || flagV !== 1'b0) begin
      errors++;
      $display("FAIL %s flags actual=%b/%b expected=%b/0 at cycle %0d", tag, act[4:0], flagV, exp[4:0], cycles);
    end
    if (rstReq === 1'b1) reqSeen++;
  endtask

  task automatic run(int n, bit v, logic [7:0] op, bit run_en);
    for (int i = 0; i < n; i++) begin
      opValid = v; opCode = op; runEn = run_en;
      @(negedge clk);
      compare();
    end
    opValid = 0; opCode = 8'h00; runEn = 1;
  endtask

  task automatic countReq(string t, int expN);
    checks++;
    if (reqSeen != expN) begin
      errors++;
      $display("FAIL %s request count actual=%0d expected=%0d", t, reqSeen, expN);
    end
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    tag = "R1"; compare();
    rstN = 1;
    run(1, 0, 8'h00, 1);
    // R2: disarmed, long idle
    tag = "R2"; reqSeen = 0; run(3 * TIMEOUT, 0, 8'h00, 1); countReq("R2", 0);
    // R6: other opcodes / strobe low do not arm
    tag = "R6"; reqSeen = 0;
    run(1, 1, 8'h5E, 1); run(1, 1, 8'h6F, 1); run(1, 1, 8'hFF, 1);
    run(1, 0, 8'h5F, 1); run(2 * TIMEOUT, 0, 8'h00, 1); countReq("R6", 0);
    // R3/R7: arm, then silence; R5: pulse then repeat
    tag = "R3"; reqSeen = 0;
    run(1, 1, 8'h5F, 1); run(TIMEOUT, 0, 8'h00, 1); countReq("R3", 1);
    tag = "R5"; run(TIMEOUT + 1, 0, 8'h00, 1); countReq("R5", 2);
    // R4: refresh every TIMEOUT-2 cycles
    tag = "R4"; reqSeen = 0;
    for (int k = 0; k < 5; k++) begin
      run(1, 1, 8'h5F, 1); run(TIMEOUT - 3, 0, 8'h00, 1);
    end
    countReq("R4", 0);
    // R9: refresh on the expiry edge
    tag = "R9"; reqSeen = 0;
    run(1, 1, 8'h5F, 1); run(TIMEOUT - 1, 0, 8'h00, 1); run(1, 1, 8'h5F, 1);
    run(TIMEOUT - 1, 0, 8'h00, 1); countReq("R9", 0);
    run(1, 0, 8'h00, 1); countReq("R9", 1);
    // R6: armed, other opcodes do not refresh
    tag = "R6"; reqSeen = 0;
    run(1, 1, 8'h5F, 1); run(4, 0, 8'h00, 1); run(TIMEOUT - 4, 1, 8'h5E, 1);
    countReq("R6", 1);
    // R8: runEn low freezes
    tag = "R8"; reqSeen = 0;
    run(1, 1, 8'h5F, 1); run(5, 0, 8'h00, 1); run(3 * TIMEOUT, 0, 8'h00, 0);
    countReq("R8", 0);
    run(TIMEOUT - 5, 0, 8'h00, 1); countReq("R8", 1);
    // R10: reset disarms
    tag = "R10"; run(1, 1, 8'h5F, 1); run(3, 0, 8'h00, 1);
    rstN = 0; run(2, 0, 8'h00, 1); rstN = 1;
    tag = "R1"; run(1, 0, 8'h00, 1);
    tag = "R10"; reqSeen = 0; run(3 * TIMEOUT, 0, 8'h00, 1); countReq("R10", 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule